// File: doc/BRIEF.md
# Isolated Key Vault with Wrapped Transport

This block stores cryptographic keys apart from the general data path. It holds two 128-bit master keys and a parameterised bank of 128-bit session keys. The master keys arrive only over a dedicated 32-bit load port. Session keys enter and leave the block only through an external block cipher that runs under a master key.

The block takes three commands. An import command deciphers a wrapped block from the data side and stores the result in a session slot. An export command enciphers a session slot and returns the ciphertext. A generate command takes a block from a random source, deciphers it under a master key and stores it in a slot.

The data side has no path that carries a key in clear. The only port that shows a key in clear is a one-way key output to the cipher. While a command is in flight, that port carries the selected master key. At all other times it carries the session slot chosen by `use_slot`, for ordinary data ciphering.

Commands arrive on a valid/ready stream and results leave on a valid/ready stream. A command is taken in a cycle where both `cmd_valid` and `cmd_ready` are high. The block takes no new command until the current result has been taken (`rsp_valid` and `rsp_ready` both high). While `rsp_ready` is low, the result is held unchanged. The random source follows the same valid/ready rule.

Top module: `keyvault_unit`

## Requirements
- R1: Each master key is loaded as four 32-bit words, most significant word first, one word per cycle with `mk_load` high. `mk_load_sel` chooses the key: 0 is the encryption master, 1 is the authentication master. `mk_valid` rises once four words have reached each key, and it then stays high.
- R2: Commands use these `cmd_op` codes: 0 = import, 1 = export, 2 = generate. If such a command is taken while `mk_valid` is low, `cmd_err` pulses in the cycle after acceptance. No result is produced, no cipher start is issued and no slot changes.
- R3: An import stores decipher(`cmd_data`, master[`cmd_mk_sel`]) into slot `cmd_slot`. Its result word is zero.
- R4: An export returns encipher(slot[`cmd_slot`], master[`cmd_mk_sel`]) on `rsp_data`. The slot is never presented on the data side in any other form.
- R5: A generate holds `rnd_ready` high and stays busy until the random source offers a block. It then stores decipher(random block, master[`cmd_mk_sel`]) into slot `cmd_slot`. Its result word is zero.
- R6: Op code 3 is reserved. It is rejected with a `cmd_err` pulse, no result and no state change.
- R7: Each command pulses `cph_start` for exactly one cycle. During that command the cipher key port carries master[`cmd_mk_sel`]. `cph_decrypt` is high for import and generate and low for export. `busy` is high from the cycle after acceptance until `cph_done` has been seen.
- R8: When no command is in flight, `cph_key` presents session slot[`use_slot`] in clear.
- R9: A pending result holds `rsp_data` stable while `rsp_ready` is low, and `cmd_ready` stays low until the result is taken.
- R10: After reset, every slot and master key is zero, `mk_valid`, `busy`, `rsp_valid` and `cmd_err` are low, and `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mk_load | input | 1 | Master key word strobe |
| mk_load_sel | input | 1 | Master key chosen for loading (0 encryption, 1 authentication) |
| mk_load_word | input | 32 | Master key word, most significant first |
| mk_valid | output | 1 | Both master keys fully loaded |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_op | input | 2 | 0 import, 1 export, 2 generate, 3 reserved |
| cmd_slot | input | SLOT_W | Session slot index |
| cmd_mk_sel | input | 1 | Master key used for the command |
| cmd_data | input | 128 | Wrapped key block for import |
| cmd_err | output | 1 | One-cycle rejection pulse |
| rsp_valid | output | 1 | Result offered |
| rsp_ready | input | 1 | Result can be taken |
| rsp_data | output | 128 | Wrapped key for export, zero otherwise |
| rnd_valid | input | 1 | Random block offered |
| rnd_ready | output | 1 | Random block can be taken |
| rnd_data | input | 128 | Random block |
| cph_start | output | 1 | Cipher start pulse |
| cph_decrypt | output | 1 | 1 decipher, 0 encipher |
| cph_din | output | 128 | Cipher input block |
| cph_key | output | 128 | One-way key output to the cipher |
| cph_dout | input | 128 | Cipher result |
| cph_done | input | 1 | One-cycle cipher completion |
| use_slot | input | SLOT_W | Session slot shown on the key port while idle |
| busy | output | 1 | Command in progress |

## Verification
The bench sends commands while only one master key has been loaded. A design that sets the valid flag early, or that lets the command through, would write a slot or start the cipher, and a later export of that slot would show it. It stalls the random source during a generate, which catches a design that stores a stale or zero block. It holds back `rsp_ready`, which catches a result that drifts or a command that slips in behind it. A design that loads words in the wrong order, or that uses the wrong master for a command, produces wrapped values that miss the bench's expected values. The bench also reads the idle key port after an import, which exposes a write to the wrong slot.

// File: rtl/kv_pkg.sv
package kv_pkg;
  typedef enum logic [1:0] {
    OP_IMPORT   = 2'd0,
    OP_EXPORT   = 2'd1,
    OP_GENERATE = 2'd2,
    OP_RSVD     = 2'd3
  } kv_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RAND,
    ST_START,
    ST_WAIT,
    ST_RESP
  } kv_state_e;
endpackage

// File: rtl/kv_master_store.sv
module kv_master_store #(
  parameter int KEY_W  = 128,
  parameter int WORD_W = 32,
  localparam int WORDS = KEY_W / WORD_W,
  localparam int CNT_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              wr_sel,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              rd_sel,
  output logic [KEY_W-1:0]  rd_key,
  output logic              all_loaded
);
  logic [KEY_W-1:0] key_q  [2];
  logic [1:0]       full_q;

  for (genvar k = 0; k < 2; k++) begin : g_mkey
    logic [CNT_W-1:0] cnt_q;
    logic             hit;
    assign hit = wr && (wr_sel == k[0]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        key_q[k]  <= '0;
        cnt_q     <= '0;
        full_q[k] <= 1'b0;
      end else if (hit) begin
        key_q[k] <= {key_q[k][KEY_W-WORD_W-1:0], wr_word};
        if (cnt_q == CNT_W'(WORDS - 1)) begin
          cnt_q     <= '0;
          full_q[k] <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign rd_key     = rd_sel ? key_q[1] : key_q[0];
  assign all_loaded = &full_q;
endmodule

// File: rtl/kv_slot_bank.sv
module kv_slot_bank #(
  parameter int KEY_W     = 128,
  parameter int NUM_SLOTS = 4,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SLOT_W-1:0] waddr,
  input  logic [KEY_W-1:0]  wdata,
  input  logic [SLOT_W-1:0] raddr_a,
  output logic [KEY_W-1:0]  rdata_a,
  input  logic [SLOT_W-1:0] raddr_b,
  output logic [KEY_W-1:0]  rdata_b
);
  logic [KEY_W-1:0] slot_q [NUM_SLOTS];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        slot_q[s] <= '0;
      else if (we && (waddr == SLOT_W'(s)))
        slot_q[s] <= wdata;
    end
  end

  assign rdata_a = slot_q[raddr_a];
  assign rdata_b = slot_q[raddr_b];
endmodule

// File: rtl/kv_sequencer.sv
module kv_sequencer
  import kv_pkg::*;
#(
  parameter int KEY_W     = 128,
  parameter int NUM_SLOTS = 4,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mk_valid,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [SLOT_W-1:0] cmd_slot,
  input  logic              cmd_mk_sel,
  input  logic [KEY_W-1:0]  cmd_data,
  output logic              cmd_err,
  input  logic [KEY_W-1:0]  slot_rdata,
  output logic              slot_we,
  output logic [SLOT_W-1:0] slot_waddr,
  output logic [KEY_W-1:0]  slot_wdata,
  input  logic              rnd_valid,
  output logic              rnd_ready,
  input  logic [KEY_W-1:0]  rnd_data,
  output logic              cph_start,
  output logic              cph_decrypt,
  output logic [KEY_W-1:0]  cph_din,
  input  logic [KEY_W-1:0]  cph_dout,
  input  logic              cph_done,
  output logic              in_flight,
  output logic              mk_sel,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [KEY_W-1:0]  rsp_data,
  output logic              busy
);
  kv_state_e         state_q;
  kv_op_e            op_q;
  logic [SLOT_W-1:0] slot_q;
  logic              sel_q;
  logic [KEY_W-1:0]  din_q;
  logic [KEY_W-1:0]  rsp_q;
  logic              err_q;
  logic              reject;

  assign reject = !mk_valid || (kv_op_e'(cmd_op) == OP_RSVD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= OP_IMPORT;
      slot_q  <= '0;
      sel_q   <= 1'b0;
      din_q   <= '0;
      rsp_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (cmd_valid) begin
            if (reject) begin
              err_q <= 1'b1;
            end else begin
              op_q   <= kv_op_e'(cmd_op);
              slot_q <= cmd_slot;
              sel_q  <= cmd_mk_sel;
              case (kv_op_e'(cmd_op))
                OP_IMPORT: begin
                  din_q   <= cmd_data;
                  state_q <= ST_START;
                end
                OP_EXPORT: begin
                  din_q   <= slot_rdata;
                  state_q <= ST_START;
                end
                default: state_q <= ST_RAND;
              endcase
            end
          end
        end
        ST_RAND: begin
          if (rnd_valid) begin
            din_q   <= rnd_data;
            state_q <= ST_START;
          end
        end
        ST_START: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (cph_done) begin
            rsp_q   <= (op_q == OP_EXPORT) ? cph_dout : '0;
            state_q <= ST_RESP;
          end
        end
        ST_RESP: begin
          if (rsp_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready   = (state_q == ST_IDLE);
  assign cmd_err     = err_q;
  assign rnd_ready   = (state_q == ST_RAND);
  assign cph_start   = (state_q == ST_START);
  assign cph_decrypt = (op_q != OP_EXPORT);
  assign cph_din     = din_q;
  assign in_flight   = (state_q == ST_START) || (state_q == ST_WAIT);
  assign busy        = in_flight || (state_q == ST_RAND);
  assign mk_sel      = sel_q;
  assign rsp_valid   = (state_q == ST_RESP);
  assign rsp_data    = rsp_q;

  assign slot_we     = (state_q == ST_WAIT) && cph_done && (op_q != OP_EXPORT);
  assign slot_waddr  = slot_q;
  assign slot_wdata  = cph_dout;
endmodule

// File: rtl/keyvault_unit.sv
module keyvault_unit #(
  parameter int KEY_W     = 128,
  parameter int WORD_W    = 32,
  parameter int NUM_SLOTS = 4,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mk_load,
  input  logic              mk_load_sel,
  input  logic [WORD_W-1:0] mk_load_word,
  output logic              mk_valid,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [SLOT_W-1:0] cmd_slot,
  input  logic              cmd_mk_sel,
  input  logic [KEY_W-1:0]  cmd_data,
  output logic              cmd_err,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [KEY_W-1:0]  rsp_data,
  input  logic              rnd_valid,
  output logic              rnd_ready,
  input  logic [KEY_W-1:0]  rnd_data,
  output logic              cph_start,
  output logic              cph_decrypt,
  output logic [KEY_W-1:0]  cph_din,
  output logic [KEY_W-1:0]  cph_key,
  input  logic [KEY_W-1:0]  cph_dout,
  input  logic              cph_done,
  input  logic [SLOT_W-1:0] use_slot,
  output logic              busy
);
  logic              mk_sel;
  logic [KEY_W-1:0]  master_key;
  logic              slot_we;
  logic [SLOT_W-1:0] slot_waddr;
  logic [KEY_W-1:0]  slot_wdata;
  logic [KEY_W-1:0]  wrap_src;
  logic [KEY_W-1:0]  use_key;
  logic              in_flight;

  kv_master_store #(.KEY_W(KEY_W), .WORD_W(WORD_W)) u_master (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (mk_load),
    .wr_sel     (mk_load_sel),
    .wr_word    (mk_load_word),
    .rd_sel     (mk_sel),
    .rd_key     (master_key),
    .all_loaded (mk_valid)
  );

  kv_slot_bank #(.KEY_W(KEY_W), .NUM_SLOTS(NUM_SLOTS)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (slot_we),
    .waddr   (slot_waddr),
    .wdata   (slot_wdata),
    .raddr_a (cmd_slot),
    .rdata_a (wrap_src),
    .raddr_b (use_slot),
    .rdata_b (use_key)
  );

  kv_sequencer #(.KEY_W(KEY_W), .NUM_SLOTS(NUM_SLOTS)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .mk_valid    (mk_valid),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .cmd_op      (cmd_op),
    .cmd_slot    (cmd_slot),
    .cmd_mk_sel  (cmd_mk_sel),
    .cmd_data    (cmd_data),
    .cmd_err     (cmd_err),
    .slot_rdata  (wrap_src),
    .slot_we     (slot_we),
    .slot_waddr  (slot_waddr),
    .slot_wdata  (slot_wdata),
    .rnd_valid   (rnd_valid),
    .rnd_ready   (rnd_ready),
    .rnd_data    (rnd_data),
    .cph_start   (cph_start),
    .cph_decrypt (cph_decrypt),
    .cph_din     (cph_din),
    .cph_dout    (cph_dout),
    .cph_done    (cph_done),
    .in_flight   (in_flight),
    .mk_sel      (mk_sel),
    .rsp_valid   (rsp_valid),
    .rsp_ready   (rsp_ready),
    .rsp_data    (rsp_data),
    .busy        (busy)
  );

  // The clear key leaves only toward the cipher: a master key while a
  // command runs, the chosen session slot otherwise.
  assign cph_key = in_flight ? master_key : use_key;
endmodule

// File: rtl/kv_checker.sv
module kv_checker #(
  parameter int KEY_W = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mk_valid,
  input logic             cmd_ready,
  input logic             cmd_err,
  input logic             busy,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [KEY_W-1:0] rsp_data,
  input logic             rnd_ready,
  input logic             cph_start
);
  // R1
  mk_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mk_valid |=> mk_valid);

  // R2
  no_cipher_unkeyed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mk_valid |-> !cph_start);

  // R2
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> (!busy && !rsp_valid));

  // R5
  rnd_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_ready |-> (busy && !cph_start));

  // R7
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cph_start |=> !cph_start);

  // R7
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cph_start |-> busy);

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R9
  rsp_blocks_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !cmd_ready);
endmodule

bind keyvault_unit kv_checker #(.KEY_W(KEY_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mk_valid  (mk_valid),
  .cmd_ready (cmd_ready),
  .cmd_err   (cmd_err),
  .busy      (busy),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data),
  .rnd_ready (rnd_ready),
  .cph_start (cph_start)
);

// File: tb/sim_keyvault_unit.sv
`timescale 1ns/1ps
module sim_keyvault_unit;
  localparam int KW = 128;
  localparam int SW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mk_load = 1'b0, mk_load_sel = 1'b0;
  logic [31:0]   mk_load_word = '0;
  logic          mk_valid;
  logic          cmd_valid = 1'b0, cmd_ready, cmd_mk_sel = 1'b0, cmd_err;
  logic [1:0]    cmd_op = '0;
  logic [SW-1:0] cmd_slot = '0, use_slot = '0;
  logic [KW-1:0] cmd_data = '0, rsp_data, rnd_data = '0;
  logic          rsp_valid, rsp_ready = 1'b1;
  logic          rnd_valid = 1'b0, rnd_ready;
  logic          cph_start, cph_decrypt, cph_done = 1'b0, busy;
  logic [KW-1:0] cph_din, cph_key, cph_dout = '0;

  always #4 clk = ~clk;

  keyvault_unit u0 (
    .clk(clk), .rst_n(rst_n), .mk_load(mk_load), .mk_load_sel(mk_load_sel),
    .mk_load_word(mk_load_word), .mk_valid(mk_valid), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_slot(cmd_slot),
    .cmd_mk_sel(cmd_mk_sel), .cmd_data(cmd_data), .cmd_err(cmd_err),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rnd_valid(rnd_valid), .rnd_ready(rnd_ready), .rnd_data(rnd_data),
    .cph_start(cph_start), .cph_decrypt(cph_decrypt), .cph_din(cph_din),
    .cph_key(cph_key), .cph_dout(cph_dout), .cph_done(cph_done),
    .use_slot(use_slot), .busy(busy)
  );

  int errors = 0, checks = 0, starts = 0;
  bit finished = 0;
  logic [KW-1:0] exp_q[$];
  logic [KW-1:0] seen_key;
  logic          seen_dec, seen_busy;

  localparam logic [KW-1:0] MK0 = 128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0;
  localparam logic [KW-1:0] MK1 = 128'h13579bdf_02468ace_fdb97531_eca86420;

  function automatic logic [KW-1:0] enc(input logic [KW-1:0] x, input logic [KW-1:0] k);
    logic [KW-1:0] r;
    r = x ^ k;
    return {r[KW-9:0], r[KW-1:KW-8]};
  endfunction

  function automatic logic [KW-1:0] dec(input logic [KW-1:0] y, input logic [KW-1:0] k);
    return {y[7:0], y[KW-1:8]} ^ k;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [KW-1:0] act,
                     input logic [KW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // stand-in cipher: fixed latency, one-cycle done
  initial begin
    forever begin
      @(negedge clk);
      if (cph_start) begin
        logic [KW-1:0] r;
        starts++;
        seen_key  = cph_key;
        seen_dec  = cph_decrypt;
        seen_busy = busy;
        r = cph_decrypt ? dec(cph_din, cph_key) : enc(cph_din, cph_key);
        repeat (3) @(negedge clk);
        cph_dout = r;
        cph_done = 1'b1;
        @(negedge clk);
        cph_done = 1'b0;
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) chk(1'b0, "R4 unexpected result", rsp_data, '0);
      else begin
        logic [KW-1:0] e;
        e = exp_q.pop_front();
        chk(rsp_data == e, "R3/R4/R5 result word", rsp_data, e);
      end
    end
  end

  task automatic load_mk(input logic sel, input logic [KW-1:0] k);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      mk_load = 1'b1; mk_load_sel = sel;
      mk_load_word = k[KW-1-32*i -: 32];
    end
    @(negedge clk);
    mk_load = 1'b0;
  endtask

  task automatic send(input logic [1:0] op, input logic [SW-1:0] slot, input logic sel,
                      input logic [KW-1:0] d, output logic err);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_slot = slot; cmd_mk_sel = sel; cmd_data = d;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    err = cmd_err;
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0 || !cmd_ready) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic e;
    int s0;
    logic [KW-1:0] D1, RB, D3, held, s1v;
    D1 = 128'hdeadbeef_01234567_89abcdef_cafef00d;
    RB = 128'h5a5a1234_a5a5fedc_33cc77ee_0badc0de;
    D3 = 128'h11112222_33334444_55556666_77778888;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(cmd_ready && !mk_valid && !busy && !rsp_valid && !cmd_err, "R10 idle flags",
        {cmd_ready, mk_valid, busy, rsp_valid, cmd_err}, 5'b10000);
    chk(cph_key == '0, "R10 slot zero on key port", cph_key, '0);

    // R1 half loaded
    load_mk(1'b0, MK0);
    chk(!mk_valid, "R1 valid after one key", mk_valid, 0);

    // R2 rejected before keys valid
    s0 = starts;
    send(2'd0, 2'd1, 1'b0, D1, e);
    chk(e, "R2 err pulse", e, 1);
    repeat (8) @(negedge clk);
    chk(starts == s0 && !rsp_valid && cmd_ready, "R2 no activity", starts - s0, 0);

    load_mk(1'b1, MK1);
    chk(mk_valid, "R1 valid after both keys", mk_valid, 1);

    // R4/R2: slot1 still zero, export under MK0
    exp_q.push_back(enc('0, MK0));
    send(2'd1, 2'd1, 1'b0, '0, e);
    wait_idle();
    chk(!e, "R2 no err after valid", e, 0);

    // R3 import slot1, R7 key and mode
    exp_q.push_back('0);
    send(2'd0, 2'd1, 1'b0, D1, e);
    wait_idle();
    chk(seen_key == MK0 && seen_dec && seen_busy, "R7 import key/mode/busy", seen_key, MK0);
    use_slot = 2'd1;
    s1v = dec(D1, MK0);
    @(negedge clk);
    chk(cph_key == s1v, "R8/R3 idle key port slot1", cph_key, s1v);

    // R4 export slot1 under MK1
    exp_q.push_back(enc(s1v, MK1));
    send(2'd1, 2'd1, 1'b1, '0, e);
    wait_idle();
    chk(seen_key == MK1 && !seen_dec, "R7 export key/mode", seen_key, MK1);

    // R5 generate with stalled random source
    s0 = starts;
    exp_q.push_back('0);
    send(2'd2, 2'd2, 1'b1, '0, e);
    repeat (6) @(negedge clk);
    chk(rnd_ready && busy && starts == s0, "R5 stalls for random", {rnd_ready, busy}, 2'b11);
    rnd_data = RB; rnd_valid = 1'b1;
    @(negedge clk);
    rnd_valid = 1'b0;
    wait_idle();
    exp_q.push_back(enc(dec(RB, MK1), MK0));
    send(2'd1, 2'd2, 1'b0, '0, e);
    wait_idle();

    // R6 reserved op
    s0 = starts;
    send(2'd3, 2'd1, 1'b0, D3, e);
    chk(e, "R6 err pulse", e, 1);
    repeat (6) @(negedge clk);
    chk(starts == s0 && !rsp_valid, "R6 no activity", starts - s0, 0);
    @(negedge clk);
    chk(cph_key == s1v, "R6 slot1 untouched", cph_key, s1v);

    // R9 back-pressure
    rsp_ready = 1'b0;
    exp_q.push_back(enc(s1v, MK0));
    send(2'd1, 2'd1, 1'b0, '0, e);
    while (!rsp_valid) @(negedge clk);
    held = rsp_data;
    repeat (4) @(negedge clk);
    chk(rsp_valid && rsp_data == held && !cmd_ready, "R9 result held", rsp_data, held);
    @(posedge clk); #1 rsp_ready = 1'b1;
    wait_idle();

    // R3/R8 top slot
    exp_q.push_back('0);
    send(2'd0, 2'd3, 1'b1, D3, e);
    wait_idle();
    use_slot = 2'd3;
    @(negedge clk);
    chk(cph_key == dec(D3, MK1), "R8/R3 idle key port slot3", cph_key, dec(D3, MK1));

    chk(exp_q.size() == 0, "R4 all results seen", exp_q.size(), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule